// File: doc/BRIEF.md
# Firmware Mailbox Message Sequencer

This engine sits on the host side of a power-management microcontroller and delivers one command per request through three memory-mapped mailbox registers: a message register, an argument register and a response register. A request carries a 16-bit message ID, a 32-bit parameter and a flag saying whether that parameter is present. The engine answers with a one-cycle completion pulse that carries a status code and a 32-bit readback word.

Each transaction starts with a firmware liveness check. The engine writes a fixed index value into an index register and reads the paired data register. A flag bit in that word must be set before the mailbox is touched. The engine then waits for any earlier command to finish, clears the response register, writes the optional argument and then the message ID, and polls for the reply. When the reply is success, the engine reads the argument register back so that commands which return data (for example an interface-version query) deliver their value. Every register access goes out on a simple request/acknowledge register-bus master port, one access at a time.

Top module: `mbx_sequencer`

## Requirements
- R1: While reset is held, `reqReady` is 1, and `busReq` and `doneValid` are 0.
- R2: The first bus access of a transaction writes 0x03B10028 (0x03B00000 OR 0x03010028) to the index register (default address 0x38). The second access reads the data register (default 0x3C).
- R3: If bit 0 (`ALIVE_BIT`) of the word read from the data register is 0, the transaction ends with status 1 (dead). `doneData` returns that word, and no message, argument or response register is accessed.
- R4: Before any mailbox write, the response register (default 0x3B168) is read repeatedly until it returns a nonzero value.
- R5: The mailbox writes are issued in this order: 0 to the response register, then the parameter to the argument register (default 0x3B148), then the message ID zero-extended to 32 bits to the message register (default 0x3B108).
- R6: After the message write, the response register is polled until it is nonzero. A value of 0x01 leads to one read of the argument register, and the transaction ends with status 0 (ok) and that register's contents on `doneData`.
- R7: Any nonzero response other than 0x01 (such as 0xFF, 0xFE, 0xFD or 0xFC) ends the transaction with status 2 (fail), with the response code on `doneData`.
- R8: A poll loop (the drain before the clear, or the reply poll) gives up after max(`tmoLimit`, 1) consecutive zero reads. It then reports status 3 (timeout) with `doneData` = 0. A drain timeout writes no mailbox register.
- R9: Only one bus access is outstanding at a time. `busReq`, `busWe`, `busAddr` and `busWdata` are held stable until `busAck`, and no access is repeated or skipped.
- R10: A request is accepted on `reqValid && reqReady`. `reqReady` is high only while idle, and `doneValid` is a single-cycle pulse.
- R11: When `reqHasParam` is 0, the argument register is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Engine idle, request can be taken |
| reqMsgId | input | 16 | Message ID |
| reqParam | input | 32 | Argument value |
| reqHasParam | input | 1 | Argument present |
| tmoLimit | input | TMO_W | Zero-read limit per poll loop |
| busReq | output | 1 | Bus access request |
| busWe | output | 1 | 1 = write, 0 = read |
| busAddr | output | 32 | Bus address |
| busWdata | output | 32 | Write data |
| busAck | input | 1 | Access complete |
| busRdata | input | 32 | Read data, valid with busAck |
| doneValid | output | 1 | Completion pulse |
| doneStatus | output | 2 | 0 ok, 1 dead, 2 fail, 3 timeout |
| doneData | output | 32 | Readback word |

## Verification
The bench targets three kinds of corner case: a firmware word with every bit set except the liveness bit, drain and reply polls that end exactly one read before the limit or exactly at it, and a zero limit that must behave like a limit of one. A design with an off-by-one counter would pass the boundary case that should fail, or fail the one that should pass. A design that skipped the liveness gate would touch the mailbox. The recorded access sequence shows whether the argument write was dropped when it was needed, issued when it was not, or swapped with the message write, which would let the firmware act on a stale argument. Every failure code is exercised, which exposes an engine that treats any nonzero reply as success.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    MBX_OK      = 2'd0,
    MBX_DEAD    = 2'd1,
    MBX_FAIL    = 2'd2,
    MBX_TIMEOUT = 2'd3
  } mbxStatus_e;

  typedef enum logic [2:0] {
    SEL_INDEX, SEL_DATA, SEL_RSP, SEL_ARG, SEL_MSG
  } busSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    load;
    logic    capRead;
    logic    cntClr;
    logic    cntInc;
    busSel_e sel;
  } dpCtl_t;
endpackage

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int          ID_W       = 16,
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 32,
  parameter int          TMO_W      = 16,
  parameter int          ALIVE_BIT  = 0,
  parameter logic [DATA_W-1:0] OK_CODE   = 1,
  parameter logic [DATA_W-1:0] LIVE_BASE = 32'h03B0_0000,
  parameter logic [DATA_W-1:0] LIVE_OFS  = 32'h0301_0028,
  parameter logic [ADDR_W-1:0] IDX_ADDR  = 32'h0000_0038,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 32'h0000_003C,
  parameter logic [ADDR_W-1:0] MSG_ADDR  = 32'h0003_B108,
  parameter logic [ADDR_W-1:0] ARG_ADDR  = 32'h0003_B148,
  parameter logic [ADDR_W-1:0] RSP_ADDR  = 32'h0003_B168
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ID_W-1:0]   reqMsgId,
  input  logic [DATA_W-1:0] reqParam,
  input  logic              reqHasParam,
  input  logic [TMO_W-1:0]  tmoLimit,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              hasParam,
  output logic              aliveOk,
  output logic              rdZero,
  output logic              rdIsOk,
  output logic              tmoHit,
  output logic [DATA_W-1:0] resData
);
  localparam logic [DATA_W-1:0] LIVE_INDEX = LIVE_BASE | LIVE_OFS;

  logic [ID_W-1:0]   msgIdQ;
  logic [DATA_W-1:0] paramQ;
  logic              hasParamQ;
  logic [TMO_W-1:0]  zeroCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgIdQ    <= '0;
      paramQ    <= '0;
      hasParamQ <= 1'b0;
      zeroCnt   <= '0;
      resData   <= '0;
    end else begin
      if (ctl.load) begin
        msgIdQ    <= reqMsgId;
        paramQ    <= reqParam;
        hasParamQ <= reqHasParam;
      end
      if (ctl.cntClr)      zeroCnt <= '0;
      else if (ctl.cntInc) zeroCnt <= zeroCnt + 1'b1;
      if (ctl.capRead)     resData <= busRdata;
    end
  end

  always_comb begin
    busAddr  = RSP_ADDR;
    busWdata = '0;
    unique case (ctl.sel)
      SEL_INDEX: begin busAddr = IDX_ADDR; busWdata = LIVE_INDEX; end
      SEL_DATA:  busAddr = DATA_ADDR;
      SEL_ARG:   begin busAddr = ARG_ADDR; busWdata = paramQ; end
      SEL_MSG:   begin busAddr = MSG_ADDR;
                       busWdata = {{(DATA_W-ID_W){1'b0}}, msgIdQ}; end
      default:   busAddr = RSP_ADDR;
    endcase
  end

  assign hasParam = hasParamQ;
  assign aliveOk  = busRdata[ALIVE_BIT];
  assign rdZero   = (busRdata == '0);
  assign rdIsOk   = (busRdata == OK_CODE);
  // a limit of 0 gives up after the first zero read, like a limit of 1
  assign tmoHit   = ({1'b0, zeroCnt} + 1'b1) >= {1'b0, tmoLimit};
endmodule

// File: rtl/mbx_control.sv
module mbx_control
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       busAck,
  input  logic       hasParam,
  input  logic       aliveOk,
  input  logic       rdZero,
  input  logic       rdIsOk,
  input  logic       tmoHit,
  output logic       reqReady,
  output logic       busReq,
  output logic       busWe,
  output logic       doneValid,
  output logic [1:0] doneStatus,
  output dpCtl_t     ctl
);
  typedef enum logic [3:0] {
    S_IDLE, S_INDEX, S_ALIVE, S_DRAIN, S_CLEAR,
    S_ARG, S_MSG, S_POLL, S_FETCH, S_DONE
  } state_e;

  state_e     state, nxt;
  mbxStatus_e status, statusNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      status <= MBX_OK;
    end else begin
      state  <= nxt;
      status <= statusNxt;
    end
  end

  always_comb begin
    nxt       = state;
    statusNxt = status;
    ctl       = '0;
    ctl.sel   = SEL_RSP;
    busReq    = 1'b0;
    busWe     = 1'b0;
    unique case (state)
      S_IDLE: if (reqValid) begin ctl.load = 1'b1; nxt = S_INDEX; end
      S_INDEX: begin
        busReq = 1'b1; busWe = 1'b1; ctl.sel = SEL_INDEX;
        if (busAck) nxt = S_ALIVE;
      end
      S_ALIVE: begin
        busReq = 1'b1; ctl.sel = SEL_DATA;
        if (busAck) begin
          ctl.capRead = 1'b1;
          if (aliveOk) begin nxt = S_DRAIN; ctl.cntClr = 1'b1; end
          else begin statusNxt = MBX_DEAD; nxt = S_DONE; end
        end
      end
      S_DRAIN: begin
        busReq = 1'b1;
        if (busAck) begin
          ctl.capRead = 1'b1;
          if (!rdZero)     nxt = S_CLEAR;
          else if (tmoHit) begin statusNxt = MBX_TIMEOUT; nxt = S_DONE; end
          else             ctl.cntInc = 1'b1;
        end
      end
      S_CLEAR: begin
        busReq = 1'b1; busWe = 1'b1;
        if (busAck) nxt = hasParam ? S_ARG : S_MSG;
      end
      S_ARG: begin
        busReq = 1'b1; busWe = 1'b1; ctl.sel = SEL_ARG;
        if (busAck) nxt = S_MSG;
      end
      S_MSG: begin
        busReq = 1'b1; busWe = 1'b1; ctl.sel = SEL_MSG;
        if (busAck) begin nxt = S_POLL; ctl.cntClr = 1'b1; end
      end
      S_POLL: begin
        busReq = 1'b1;
        if (busAck) begin
          ctl.capRead = 1'b1;
          if (!rdZero) begin
            if (rdIsOk) nxt = S_FETCH;
            else begin statusNxt = MBX_FAIL; nxt = S_DONE; end
          end else if (tmoHit) begin
            statusNxt = MBX_TIMEOUT; nxt = S_DONE;
          end else ctl.cntInc = 1'b1;
        end
      end
      S_FETCH: begin
        busReq = 1'b1; ctl.sel = SEL_ARG;
        if (busAck) begin
          ctl.capRead = 1'b1; statusNxt = MBX_OK; nxt = S_DONE;
        end
      end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign reqReady   = (state == S_IDLE);
  assign doneValid  = (state == S_DONE);
  assign doneStatus = status;
endmodule

// File: rtl/mbx_sequencer.sv
module mbx_sequencer
  import mbx_pkg::*;
#(
  parameter int          TMO_W      = 16,
  parameter int          ALIVE_BIT  = 0,
  parameter logic [31:0] IDX_ADDR   = 32'h0000_0038,
  parameter logic [31:0] DATA_ADDR  = 32'h0000_003C,
  parameter logic [31:0] MSG_ADDR   = 32'h0003_B108,
  parameter logic [31:0] ARG_ADDR   = 32'h0003_B148,
  parameter logic [31:0] RSP_ADDR   = 32'h0003_B168
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [15:0]      reqMsgId,
  input  logic [31:0]      reqParam,
  input  logic             reqHasParam,
  input  logic [TMO_W-1:0] tmoLimit,
  output logic             busReq,
  output logic             busWe,
  output logic [31:0]      busAddr,
  output logic [31:0]      busWdata,
  input  logic             busAck,
  input  logic [31:0]      busRdata,
  output logic             doneValid,
  output logic [1:0]       doneStatus,
  output logic [31:0]      doneData
);
  dpCtl_t ctl;
  logic hasParam, aliveOk, rdZero, rdIsOk, tmoHit;

  mbx_control ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .busAck(busAck),
    .hasParam(hasParam), .aliveOk(aliveOk), .rdZero(rdZero),
    .rdIsOk(rdIsOk), .tmoHit(tmoHit), .reqReady(reqReady),
    .busReq(busReq), .busWe(busWe), .doneValid(doneValid),
    .doneStatus(doneStatus), .ctl(ctl)
  );

  mbx_datapath #(
    .ID_W(16), .DATA_W(32), .ADDR_W(32), .TMO_W(TMO_W),
    .ALIVE_BIT(ALIVE_BIT), .IDX_ADDR(IDX_ADDR), .DATA_ADDR(DATA_ADDR),
    .MSG_ADDR(MSG_ADDR), .ARG_ADDR(ARG_ADDR), .RSP_ADDR(RSP_ADDR)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqMsgId(reqMsgId),
    .reqParam(reqParam), .reqHasParam(reqHasParam), .tmoLimit(tmoLimit),
    .busRdata(busRdata), .busAddr(busAddr), .busWdata(busWdata),
    .hasParam(hasParam), .aliveOk(aliveOk), .rdZero(rdZero),
    .rdIsOk(rdIsOk), .tmoHit(tmoHit), .resData(doneData)
  );
endmodule

// File: rtl/mbx_sequencer_chk.sv
module mbx_sequencer_chk #(
  parameter logic [31:0] MSG_ADDR = 32'h0003_B108,
  parameter logic [31:0] ARG_ADDR = 32'h0003_B148,
  parameter logic [31:0] RSP_ADDR = 32'h0003_B168
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        busReq,
  input logic        busWe,
  input logic [31:0] busAddr,
  input logic [31:0] busWdata,
  input logic        busAck,
  input logic        doneValid,
  input logic [1:0]  doneStatus
);
  logic sawMsgWr, sawMbx;
  logic accMbx;
  assign accMbx = busReq && busAck &&
                  (busAddr == MSG_ADDR || busAddr == ARG_ADDR || busAddr == RSP_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN || doneValid) begin
      sawMsgWr <= 1'b0;
      sawMbx   <= 1'b0;
    end else begin
      if (accMbx) sawMbx <= 1'b1;
      if (busReq && busAck && busWe && busAddr == MSG_ADDR) sawMsgWr <= 1'b1;
    end
  end

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busWe) && $stable(busAddr) && $stable(busWdata));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq || doneValid) |-> !reqReady);
  // R3
  dead_no_mbx_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneStatus == 2'd1 |-> !sawMbx);
  // R6
  msg_before_reply_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && (doneStatus == 2'd0 || doneStatus == 2'd2) |-> sawMsgWr);
endmodule

bind mbx_sequencer mbx_sequencer_chk #(
  .MSG_ADDR(MSG_ADDR), .ARG_ADDR(ARG_ADDR), .RSP_ADDR(RSP_ADDR)
) chk_i (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .busReq(busReq),
  .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busAck(busAck),
  .doneValid(doneValid), .doneStatus(doneStatus)
);

// File: tb/mbx_sequencer_tb_top.sv
module mbx_sequencer_tb_top;
  localparam logic [31:0] IDX_A  = 32'h0000_0038;
  localparam logic [31:0] DATA_A = 32'h0000_003C;
  localparam logic [31:0] MSG_A  = 32'h0003_B108;
  localparam logic [31:0] ARG_A  = 32'h0003_B148;
  localparam logic [31:0] RSP_A  = 32'h0003_B168;
  localparam logic [31:0] LIVE_W = 32'h03B1_0028;

  typedef struct packed {
    logic [15:0] id;
    logic [31:0] param;
    logic        hasP;
    logic [31:0] alive;
    logic [7:0]  drainZ;
    logic [7:0]  postZ;
    logic [7:0]  rsp;
    logic [31:0] argOut;
    logic [15:0] tmo;
    logic [1:0]  expStat;
    logic [31:0] expData;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'h0003, 32'h0,         1'b0, 32'h1,         8'd0, 8'd2, 8'h01, 32'h5,         16'd16, 2'd0, 32'h5},
    '{16'h001A, 32'h1234_5678, 1'b1, 32'h1,         8'd3, 8'd0, 8'h01, 32'hCAFE_0001, 16'd16, 2'd0, 32'hCAFE_0001},
    '{16'h0022, 32'hA5,        1'b1, 32'h1,         8'd1, 8'd1, 8'hFE, 32'h0,         16'd16, 2'd2, 32'hFE},
    '{16'h000B, 32'h0,         1'b0, 32'h8000_0001, 8'd0, 8'd0, 8'hFC, 32'h0,         16'd16, 2'd2, 32'hFC},
    '{16'h0015, 32'h7,         1'b1, 32'h1,         8'd0, 8'd3, 8'hFD, 32'h0,         16'd16, 2'd2, 32'hFD},
    '{16'h0001, 32'h0,         1'b0, 32'h1,         8'd0, 8'd0, 8'hFF, 32'h0,         16'd16, 2'd2, 32'hFF},
    '{16'h0002, 32'h0,         1'b0, 32'hFFFF_FFFE, 8'd0, 8'd0, 8'h01, 32'h0,         16'd16, 2'd1, 32'hFFFF_FFFE},
    '{16'h0007, 32'h0,         1'b0, 32'h1,         8'd0, 8'd0, 8'h00, 32'h0,         16'd5,  2'd3, 32'h0},
    '{16'h0008, 32'h55,        1'b1, 32'h1,         8'd4, 8'd0, 8'h01, 32'h0,         16'd4,  2'd3, 32'h0},
    '{16'h0009, 32'h66,        1'b1, 32'h1,         8'd3, 8'd0, 8'h01, 32'h77,        16'd4,  2'd0, 32'h77},
    '{16'h000C, 32'h0,         1'b0, 32'h1,         8'd0, 8'd2, 8'h01, 32'h0,         16'd0,  2'd3, 32'h0},
    '{16'h000E, 32'h99,        1'b1, 32'h1,         8'd0, 8'd0, 8'h01, 32'h1234,      16'd0,  2'd0, 32'h1234}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, reqValid, reqReady, reqHasParam;
  logic [15:0] reqMsgId, tmoLimit;
  logic [31:0] reqParam;
  logic busReq, busWe, busAck;
  logic [31:0] busAddr, busWdata, busRdata;
  logic doneValid;
  logic [1:0] doneStatus;
  logic [31:0] doneData;

  mbx_sequencer dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqMsgId(reqMsgId), .reqParam(reqParam), .reqHasParam(reqHasParam),
    .tmoLimit(tmoLimit), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata),
    .doneValid(doneValid), .doneStatus(doneStatus), .doneData(doneData)
  );

  // behavioural mailbox responder
  logic [31:0] cfgAlive, cfgArgOut;
  logic [7:0]  cfgDrain, cfgPost, cfgRsp;
  logic [7:0]  drainLeft, postLeft;
  logic        msgSeen;
  logic [31:0] argReg;
  logic [31:0] logAddr [64];
  logic [31:0] logData [64];
  logic        logWe   [64];
  int          logN, slot;

  always @(posedge clk) begin
    if (!rstN) begin
      busAck <= 1'b0; busRdata <= '0; logN <= 0; msgSeen <= 1'b0;
      drainLeft <= '0; postLeft <= '0; argReg <= '0;
    end else if (busReq && !busAck) begin
      busAck   <= 1'b1;
      busRdata <= '0;
      slot = (busWe && busAddr == IDX_A) ? 0 : logN;
      if (slot < 64) begin
        logAddr[slot] <= busAddr;
        logWe[slot]   <= busWe;
        logData[slot] <= busWe ? busWdata : 32'h0;
      end
      logN <= slot + 1;
      if (busWe) begin
        if (busAddr == IDX_A) begin
          drainLeft <= cfgDrain; postLeft <= cfgPost; msgSeen <= 1'b0;
        end
        if (busAddr == ARG_A) argReg  <= busWdata;
        if (busAddr == MSG_A) msgSeen <= 1'b1;
      end else begin
        if (busAddr == DATA_A) busRdata <= cfgAlive;
        if (busAddr == ARG_A)  busRdata <= argReg;
        if (busAddr == RSP_A) begin
          if (!msgSeen) begin
            if (drainLeft != 0) drainLeft <= drainLeft - 1'b1;
            else busRdata <= 32'h1;
          end else if (postLeft != 0) postLeft <= postLeft - 1'b1;
          else begin
            busRdata <= {24'h0, cfgRsp};
            if (cfgRsp == 8'h01) argReg <= cfgArgOut;
          end
        end
      end
    end else busAck <= 1'b0;
  end

  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int waitCyc, lim, k, expDrain, argWr, total;
    bit drainTmo, gotDone;
    logic [1:0] st;
    logic [31:0] dd;
    cfgAlive = v.alive; cfgArgOut = v.argOut; cfgDrain = v.drainZ;
    cfgPost = v.postZ; cfgRsp = v.rsp;
    @(negedge clk);
    reqMsgId = v.id; reqParam = v.param; reqHasParam = v.hasP;
    tmoLimit = v.tmo; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    // R10: busy after acceptance
    chk(reqReady == 1'b0, "R10", "ready while busy", {31'h0, reqReady}, 32'h0);
    gotDone = 1'b0; waitCyc = 0;
    while (!gotDone && waitCyc < 2000) begin
      if (doneValid) gotDone = 1'b1;
      else begin @(negedge clk); waitCyc++; end
    end
    chk(gotDone, "R10", "completion seen", {31'h0, gotDone}, 32'h1);
    st = doneStatus; dd = doneData;
    @(negedge clk);
    // R10: single-cycle pulse, back to idle
    chk(!doneValid && reqReady, "R10", "done pulse width",
        {30'h0, doneValid, reqReady}, 32'h1);
    case (v.expStat)
      2'd0: chk(st == v.expStat, "R6", "status", {30'h0, st}, {30'h0, v.expStat});
      2'd1: chk(st == v.expStat, "R3", "status", {30'h0, st}, {30'h0, v.expStat});
      2'd2: chk(st == v.expStat, "R7", "status", {30'h0, st}, {30'h0, v.expStat});
      default: chk(st == v.expStat, "R8", "status", {30'h0, st}, {30'h0, v.expStat});
    endcase
    chk(dd == v.expData, (v.expStat == 2'd3) ? "R8" : "R6", "doneData", dd, v.expData);
    // R2: liveness access pair
    chk(logN >= 2 && logWe[0] && logAddr[0] == IDX_A && logData[0] == LIVE_W,
        "R2", "index write", logData[0], LIVE_W);
    chk(logN >= 2 && !logWe[1] && logAddr[1] == DATA_A, "R2", "data read",
        logAddr[1], DATA_A);
    if (v.expStat == 2'd1) begin
      chk(logN == 2, "R3", "access count when dead", logN, 32'd2);
      return;
    end
    lim = (v.tmo == 0) ? 1 : int'(v.tmo);
    drainTmo = (int'(v.drainZ) >= lim);
    expDrain = drainTmo ? lim : int'(v.drainZ) + 1;
    k = 2;
    while (k < logN && k < 64 && !logWe[k] && logAddr[k] == RSP_A) k++;
    chk(k - 2 == expDrain, drainTmo ? "R8" : "R4", "drain reads", k - 2, expDrain);
    if (drainTmo) begin
      chk(logN == k, "R8", "no mailbox write after drain timeout", logN, k);
      return;
    end
    chk(logWe[k] && logAddr[k] == RSP_A && logData[k] == 0, "R5", "clear write",
        logAddr[k], RSP_A);
    k++;
    if (v.hasP) begin
      chk(logWe[k] && logAddr[k] == ARG_A && logData[k] == v.param, "R5",
          "argument write", logData[k], v.param);
      k++;
    end
    chk(logWe[k] && logAddr[k] == MSG_A && logData[k] == {16'h0, v.id}, "R5",
        "message write", logData[k], {16'h0, v.id});
    argWr = 0;
    for (int j = 0; j < logN && j < 64; j++)
      if (logWe[j] && logAddr[j] == ARG_A) argWr++;
    // R11: argument written only when present
    chk(argWr == (v.hasP ? 1 : 0), "R11", "argument write count", argWr, v.hasP);
    if (v.expStat == 2'd0) begin
      // R9: every access appears exactly once
      total = 2 + expDrain + (v.hasP ? 3 : 2) + int'(v.postZ) + 1 + 1;
      chk(logN == total, "R9", "access count", logN, total);
    end
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqMsgId = '0; reqParam = '0;
    reqHasParam = 1'b0; tmoLimit = '0;
    cfgAlive = '0; cfgArgOut = '0; cfgDrain = '0; cfgPost = '0; cfgRsp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(reqReady && !busReq && !doneValid, "R1", "reset outputs",
        {29'h0, reqReady, busReq, doneValid}, 32'h4);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busReq && reqReady, "R1", "idle after reset", {30'h0, busReq, reqReady}, 32'h1);
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);
    // directed: back-to-back with alternating parameter flag
    run_vec(VECS[1]);
    run_vec(VECS[0]);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule